// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate

This block is the enhanced-mode access path that sits behind a parallel port's host register window. A host access to the address cycle offset (3) or to the data cycle offset (4) is turned into one or more byte transfers on the peripheral side. Each transfer is a strobe/wait handshake. A transfer starts only when the stored control register holds exactly the bit pattern for that direction. In every other case the access completes at once and has no effect on the peripheral.

Data cycles can be 8, 16 or 32 bits wide. They are moved lowest byte first, as one stalled host access. Address cycles are always a single byte. If the peripheral does not raise wait within a parameterised number of clocks, the cycle is aborted and a sticky timeout flag is set. The flag is visible in bit 0 of status reads, and the host clears it by writing a 1 to that bit. The block also holds the control register and the data latch, and it reports when either one actually changes.

Top module: `epp_port`

## Requirements
- R1: An access with we_i=1 to offset 3 or 4 starts peripheral strobes only when (control & 0x2F) == 0x04. Otherwise it completes in the cycle it is presented, with no strobe.
- R2: An access with we_i=0 to offset 3 or 4 starts a peripheral cycle only when (control & 0x2F) == 0x24. Otherwise it completes at once and returns all ones for the access width: size_i 0 gives 0xFF, 1 gives 0xFFFF and 2 gives 0xFFFFFFFF. Bits above the width read as 0.
- R3: If wait_i is not seen within TMO_CYCLES clocks of a strobe, the timeout flag sets and the bytes that remain are abandoned. The flag stays set, and the bytes not received read as 0xFF.
- R4: A write to offset 1 with wdata_i[0]=1 clears the timeout flag. A write to offset 1 with wdata_i[0]=0 leaves the flag unchanged.
- R5: A read of offset 1 returns {status_i[7:1], timeout flag}.
- R6: A data cycle with size_i=1 moves 2 bytes and one with size_i=2 moves 4 bytes. Bytes go out on pd_o lowest byte first. Read bytes are assembled lowest byte first into rdata_o.
- R7: A write to offset 2 stores wdata_i | 0xC0, and a read of offset 2 returns the stored value. If the stored value does not change, the write makes no ctrl_upd_o pulse. A change of bit 5 (direction) also pulses dir_chg_o.
- R8: A write to offset 0 pulses data_upd_o and loads the latch shown on pd_o only if the byte differs from the last byte written.
- R9: During a peripheral cycle, ready_o stays low until every byte has completed or the cycle has timed out. ready_o is then high for one clock. An address cycle moves exactly one byte.
- R10: After reset the timeout flag is 0, control is 0xCC, the data latch is 0xFF and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register offset (0 data, 1 status, 2 control, 3 address cycle, 4 data cycle) |
| size_i | input | 2 | Data cycle width: 0 = 8, 1 = 16, 2 = 32 bits |
| wdata_i | input | DW | Host write data |
| rdata_o | output | DW | Host read data, valid while ready_o is high |
| ready_o | output | 1 | Access complete |
| pd_o | output | 8 | Peripheral data out |
| pd_i | input | 8 | Peripheral data in |
| pd_oe_o | output | 1 | Drive pd_o (control bit 5 clear) |
| ctrl_o | output | 4 | Control line levels (control bits 3:0) |
| addr_strb_o | output | 1 | Address cycle strobe |
| data_strb_o | output | 1 | Data cycle strobe |
| pwrite_o | output | 1 | Current cycle is a write |
| wait_i | input | 1 | Peripheral byte acknowledge |
| status_i | input | 8 | Peripheral status lines |
| ctrl_upd_o | output | 1 | Pulse: control value changed |
| dir_chg_o | output | 1 | Pulse: direction bit changed |
| data_upd_o | output | 1 | Pulse: data latch changed |

## Verification
The gate is tried with the reset control value, with the write pattern 0x04 and with the read pattern 0x24. Each pattern is tried for both reads and writes, so a wrong mask or an exchanged pattern shows up as strobes where none belong. Data cycles of one, two and four bytes use distinct byte values, so the order of bytes on pd_o and the assembly order in rdata_o are both observed. Timeout is provoked by a peripheral that never answers. The flag is then cleared with bit 0 low and with bit 0 high. Repeated identical writes to the control and data registers separate a real change from a suppressed one.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [2:0] {
    OFF_DATA  = 3'd0,
    OFF_STAT  = 3'd1,
    OFF_CTRL  = 3'd2,
    OFF_EADDR = 3'd3,
    OFF_EDATA = 3'd4
  } reg_off_e;

  typedef enum logic [1:0] {X_IDLE, X_BYTE, X_GAP, X_DONE} xfer_st_e;

  localparam logic [7:0] GATE_MASK  = 8'h2F;
  localparam logic [7:0] GATE_WR    = 8'h04;
  localparam logic [7:0] GATE_RD    = 8'h24;
  localparam logic [7:0] CTRL_FORCE = 8'hC0;
  localparam logic [7:0] CTRL_RST   = 8'hCC;
  localparam logic [7:0] DATA_RST   = 8'hFF;
endpackage

// File: rtl/epp_gate.sv
module epp_gate
  import epp_pkg::*;
#(
  parameter int DW   = 32,
  localparam int BYTES = DW / 8,
  localparam int NB_W  = $clog2(BYTES + 1)
) (
  input  logic            req_i,
  input  logic            idle_i,
  input  logic            we_i,
  input  logic [2:0]      addr_i,
  input  logic [1:0]      size_i,
  input  logic [7:0]      ctrl_i,
  output logic            start_o,
  output logic            is_addr_o,
  output logic [NB_W-1:0] nbytes_o,
  output logic            imm_o
);
  logic epp_off, pat_ok;

  assign epp_off   = (addr_i == OFF_EADDR) || (addr_i == OFF_EDATA);
  assign is_addr_o = (addr_i == OFF_EADDR);
  assign pat_ok    = we_i ? ((ctrl_i & GATE_MASK) == GATE_WR)
                          : ((ctrl_i & GATE_MASK) == GATE_RD);

  always_comb begin
    if (is_addr_o)          nbytes_o = NB_W'(1);
    else if (size_i == 2'd0) nbytes_o = NB_W'(1);
    else if (size_i == 2'd1) nbytes_o = NB_W'(2);
    else                     nbytes_o = NB_W'(BYTES);
  end

  assign start_o = req_i && idle_i && epp_off && pat_ok;
  assign imm_o   = req_i && idle_i && !start_o;
endmodule

// File: rtl/epp_regs.sv
module epp_regs
  import epp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       tmo_set_i,
  output logic [7:0] ctrl_o,
  output logic [7:0] data_o,
  output logic       tmo_o,
  output logic       ctrl_upd_o,
  output logic       dir_chg_o,
  output logic       data_upd_o
);
  logic [7:0] ctrl_new;
  logic       ctrl_wr, data_wr, tmo_clr;

  assign ctrl_new = wdata_i | CTRL_FORCE;
  assign ctrl_wr  = wr_i && (addr_i == OFF_CTRL) && (ctrl_new != ctrl_o);
  assign data_wr  = wr_i && (addr_i == OFF_DATA) && (wdata_i != data_o);
  assign tmo_clr  = wr_i && (addr_i == OFF_STAT) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o     <= CTRL_RST;
      data_o     <= DATA_RST;
      tmo_o      <= 1'b0;
      ctrl_upd_o <= 1'b0;
      dir_chg_o  <= 1'b0;
      data_upd_o <= 1'b0;
    end else begin
      ctrl_upd_o <= ctrl_wr;
      dir_chg_o  <= ctrl_wr && (ctrl_new[5] != ctrl_o[5]);
      data_upd_o <= data_wr;
      if (ctrl_wr) ctrl_o <= ctrl_new;
      if (data_wr) data_o <= wdata_i;
      if (tmo_set_i)    tmo_o <= 1'b1;
      else if (tmo_clr) tmo_o <= 1'b0;
    end
  end

  AST_CTRL_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[7:6] == 2'b11); // R7
  AST_TMO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o && !(wr_i && addr_i == OFF_STAT && wdata_i[0]) |=> tmo_o); // R3
  AST_TMO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == OFF_STAT && wdata_i[0] && !tmo_set_i |=> !tmo_o); // R4
  AST_DATA_CHANGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_upd_o |-> data_o != $past(data_o)); // R8
endmodule

// File: rtl/epp_xfer.sv
module epp_xfer
  import epp_pkg::*;
#(
  parameter int DW         = 32,
  parameter int TMO_CYCLES = 1000,
  localparam int BYTES = DW / 8,
  localparam int NB_W  = $clog2(BYTES + 1),
  localparam int IDX_W = $clog2(BYTES),
  localparam int CNT_W = $clog2(TMO_CYCLES + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            is_addr_i,
  input  logic            is_wr_i,
  input  logic [NB_W-1:0] nbytes_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [7:0]      pd_i,
  input  logic            wait_i,
  output logic            idle_o,
  output logic            done_o,
  output logic [DW-1:0]   rdata_o,
  output logic [7:0]      byte_o,
  output logic            drive_o,
  output logic            addr_strb_o,
  output logic            data_strb_o,
  output logic            pwrite_o,
  output logic            tmo_set_o
);
  xfer_st_e          st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [NB_W-1:0]   nb_q;
  logic [DW-1:0]     wbuf_q, rbuf_q, mask;
  logic              addr_q, wr_q, last_byte;

  assign last_byte = (NB_W'(idx_q) + NB_W'(1)) == nb_q;
  assign tmo_set_o = (st_q == X_BYTE) && !wait_i && (cnt_q == CNT_W'(TMO_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= X_IDLE;
      idx_q  <= '0;
      cnt_q  <= '0;
      nb_q   <= '0;
      wbuf_q <= '0;
      rbuf_q <= '1;
      addr_q <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      case (st_q)
        X_IDLE: if (start_i) begin
          st_q   <= X_BYTE;
          idx_q  <= '0;
          cnt_q  <= '0;
          nb_q   <= nbytes_i;
          wbuf_q <= wdata_i;
          rbuf_q <= '1;
          addr_q <= is_addr_i;
          wr_q   <= is_wr_i;
        end
        X_BYTE: begin
          if (wait_i) begin
            cnt_q <= '0;
            if (!wr_q) rbuf_q[{idx_q, 3'b000} +: 8] <= pd_i;
            if (last_byte) st_q <= X_DONE;
            else begin
              st_q  <= X_GAP;
              idx_q <= idx_q + IDX_W'(1);
            end
          end else if (tmo_set_o) begin
            st_q <= X_DONE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        X_GAP:   st_q <= X_BYTE;
        default: st_q <= X_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < BYTES; i++)
      mask[i*8 +: 8] = (NB_W'(i) < nb_q) ? 8'hFF : 8'h00;
  end

  assign idle_o      = (st_q == X_IDLE);
  assign done_o      = (st_q == X_DONE);
  assign rdata_o     = wr_q ? '0 : (rbuf_q & mask);
  assign byte_o      = wbuf_q[{idx_q, 3'b000} +: 8];
  assign drive_o     = wr_q && (st_q != X_IDLE);
  assign addr_strb_o = (st_q == X_BYTE) && addr_q;
  assign data_strb_o = (st_q == X_BYTE) && !addr_q;
  assign pwrite_o    = wr_q && (st_q != X_IDLE);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(TMO_CYCLES)); // R3
  AST_DONE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == X_DONE |=> st_q == X_IDLE); // R9
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({addr_strb_o, data_strb_o})); // R9
  AST_ADDR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q && st_q == X_GAP |-> 1'b0); // R9
endmodule

// File: rtl/epp_port.sv
module epp_port
  import epp_pkg::*;
#(
  parameter int DW     = 32,
  parameter int CLK_HZ = 100_000_000,
  parameter int TMO_US = 10,
  localparam int BYTES      = DW / 8,
  localparam int NB_W       = $clog2(BYTES + 1),
  localparam int TMO_CYCLES = (CLK_HZ / 1_000_000) * TMO_US
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          ready_o,
  output logic [7:0]    pd_o,
  input  logic [7:0]    pd_i,
  output logic          pd_oe_o,
  output logic [3:0]    ctrl_o,
  output logic          addr_strb_o,
  output logic          data_strb_o,
  output logic          pwrite_o,
  input  logic          wait_i,
  input  logic [7:0]    status_i,
  output logic          ctrl_upd_o,
  output logic          dir_chg_o,
  output logic          data_upd_o
);
  logic            idle, done, start, is_addr, imm, tmo_set, tmo_q, drive;
  logic [NB_W-1:0] nbytes;
  logic [7:0]      ctrl_q, data_q, xbyte;
  logic [DW-1:0]   xrdata, imm_mask;

  epp_gate #(.DW(DW)) u_gate (
    .req_i(req_i), .idle_i(idle), .we_i(we_i), .addr_i(addr_i),
    .size_i(size_i), .ctrl_i(ctrl_q), .start_o(start),
    .is_addr_o(is_addr), .nbytes_o(nbytes), .imm_o(imm)
  );

  epp_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(imm && we_i), .addr_i(addr_i),
    .wdata_i(wdata_i[7:0]), .tmo_set_i(tmo_set), .ctrl_o(ctrl_q),
    .data_o(data_q), .tmo_o(tmo_q), .ctrl_upd_o(ctrl_upd_o),
    .dir_chg_o(dir_chg_o), .data_upd_o(data_upd_o)
  );

  epp_xfer #(.DW(DW), .TMO_CYCLES(TMO_CYCLES)) u_xfer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .is_addr_i(is_addr),
    .is_wr_i(we_i), .nbytes_i(nbytes), .wdata_i(wdata_i), .pd_i(pd_i),
    .wait_i(wait_i), .idle_o(idle), .done_o(done), .rdata_o(xrdata),
    .byte_o(xbyte), .drive_o(drive), .addr_strb_o(addr_strb_o),
    .data_strb_o(data_strb_o), .pwrite_o(pwrite_o), .tmo_set_o(tmo_set)
  );

  always_comb begin
    for (int i = 0; i < BYTES; i++)
      imm_mask[i*8 +: 8] = (NB_W'(i) < nbytes) ? 8'hFF : 8'h00;
  end

  always_comb begin
    rdata_o = '0;
    if (done) rdata_o = xrdata;
    else if (imm && !we_i) begin
      case (addr_i)
        OFF_DATA:             rdata_o = DW'(pd_i);
        OFF_STAT:             rdata_o = DW'({status_i[7:1], tmo_q});
        OFF_CTRL:             rdata_o = DW'(ctrl_q);
        OFF_EADDR, OFF_EDATA: rdata_o = imm_mask;
        default:              rdata_o = DW'(8'hFF);
      endcase
    end
  end

  assign ready_o = done || imm;
  assign pd_o    = drive ? xbyte : data_q;
  assign pd_oe_o = !ctrl_q[5];
  assign ctrl_o  = ctrl_q[3:0];

  AST_WR_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_strb_o || data_strb_o) && pwrite_o |-> (ctrl_q & GATE_MASK) == GATE_WR); // R1
  AST_RD_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_strb_o || data_strb_o) && !pwrite_o |-> (ctrl_q & GATE_MASK) == GATE_RD); // R2
  AST_NO_READY_MIDCYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_strb_o || data_strb_o) |-> !ready_o); // R9
endmodule

// File: tb/epp_port_test.sv
module epp_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [2:0] addr = 0;
  logic [1:0] size = 0;
  logic [DW-1:0] wdata = 0, rdata;
  logic ready, pd_oe, astb, dstb, pwr, ctrl_upd, dir_chg, data_upd;
  logic [7:0] pd_o, pd_i, status;
  logic [3:0] ctrl_lines;
  logic wait_s;

  int errors = 0, checks = 0;
  int resp_en = 1, resp_dly = 0, hold = 0;
  int n_bytes = 0, n_abytes = 0, n_rbytes = 0, n_strb = 0;
  int n_cupd = 0, n_dchg = 0, n_dupd = 0;
  logic [7:0] wlog [0:63];
  logic [7:0] rd_base = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  epp_port #(.DW(DW), .CLK_HZ(2_000_000), .TMO_US(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready),
    .pd_o(pd_o), .pd_i(pd_i), .pd_oe_o(pd_oe), .ctrl_o(ctrl_lines),
    .addr_strb_o(astb), .data_strb_o(dstb), .pwrite_o(pwr), .wait_i(wait_s),
    .status_i(status), .ctrl_upd_o(ctrl_upd), .dir_chg_o(dir_chg),
    .data_upd_o(data_upd)
  );

  // peripheral model
  assign wait_s = (resp_en != 0) && (astb || dstb) && (hold >= resp_dly);
  assign pd_i   = rd_base + 8'(n_rbytes);

  always @(posedge clk) begin
    hold <= (astb || dstb) ? hold + 1 : 0;
    if ((astb || dstb) && !$past(astb || dstb)) n_strb <= n_strb + 1;
    if ((astb || dstb) && wait_s) begin
      if (pwr) begin
        wlog[n_bytes[5:0]] <= pd_o;
        n_bytes <= n_bytes + 1;
        if (astb) n_abytes <= n_abytes + 1;
      end else n_rbytes <= n_rbytes + 1;
    end
    if (ctrl_upd) n_cupd <= n_cupd + 1;
    if (dir_chg)  n_dchg <= n_dchg + 1;
    if (data_upd) n_dupd <= n_dupd + 1;
  end

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic host(input logic w, input logic [2:0] a, input logic [1:0] s,
                      input logic [31:0] d, output logic [31:0] r, output int lat);
    @(negedge clk);
    req = 1; we = w; addr = a; size = s; wdata = d; lat = 0;
    forever begin
      #1;
      if (ready) begin r = rdata; break; end
      @(negedge clk);
      lat++;
    end
    @(posedge clk);
    @(negedge clk);
    req = 0;
  endtask

  task automatic t_reset();
    logic [31:0] r; int l;
    chk("R10 no strobe", {30'd0, astb, dstb}, 0);
    chk("R10 data latch", pd_o, 8'hFF);
    host(0, 3'd1, 0, 0, r, l);
    chk("R5 R10 status flag clear", r, 32'h000000A6);
    host(0, 3'd2, 0, 0, r, l);
    chk("R10 control reset", r, 32'hCC);
  endtask

  task automatic t_gate_write();
    logic [31:0] r; int l, s0;
    s0 = n_strb;
    host(1, 3'd4, 2, 32'hDEADBEEF, r, l);
    chk("R1 gated write no strobe", n_strb - s0, 0);
    chk("R1 gated write immediate", l, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] r; int l, c0;
    c0 = n_cupd;
    host(1, 3'd2, 0, 32'h04, r, l);
    host(0, 3'd2, 0, 0, r, l);
    chk("R7 forced bits", r, 32'hC4);
    host(1, 3'd2, 0, 32'hC4, r, l);
    repeat (2) @(negedge clk);
    chk("R7 equal write suppressed", n_cupd - c0, 1);
  endtask

  task automatic t_addr_write();
    logic [31:0] r; int l, b0, a0;
    b0 = n_bytes; a0 = n_abytes;
    host(1, 3'd3, 2, 32'h1234565A, r, l);
    chk("R9 address one byte", n_abytes - a0, 1);
    chk("R1 address byte value", wlog[b0[5:0]], 8'h5A);
  endtask

  task automatic t_data_write(input logic [1:0] s, input logic [31:0] d, input int nb);
    logic [31:0] r; int l, b0;
    b0 = n_bytes;
    host(1, 3'd4, s, d, r, l);
    chk("R9 all bytes before ready", n_bytes - b0, nb);
    for (int i = 0; i < nb; i++)
      chk("R6 write byte order", wlog[6'(b0 + i)], d[i*8 +: 8]);
  endtask

  task automatic t_gate_read();
    logic [31:0] r; int l, s0;
    s0 = n_strb;
    host(0, 3'd4, 0, 0, r, l);
    chk("R2 gated read 8", r, 32'hFF);
    host(0, 3'd4, 1, 0, r, l);
    chk("R2 gated read 16", r, 32'hFFFF);
    host(0, 3'd3, 0, 0, r, l);
    chk("R2 gated addr read", r, 32'hFF);
    chk("R2 gated read no strobe", n_strb - s0, 0);
  endtask

  task automatic t_read_mode();
    logic [31:0] r; int l, d0, s0;
    d0 = n_dchg;
    host(1, 3'd2, 0, 32'h24, r, l);
    repeat (2) @(negedge clk);
    chk("R7 direction change pulse", n_dchg - d0, 1);
    chk("R7 drive off when reading", pd_oe, 1'b0);
    rd_base = 8'h10 - 8'(n_rbytes);
    host(0, 3'd4, 2, 0, r, l);
    chk("R6 read assembly", r, 32'h13121110);
    rd_base = 8'hA0 - 8'(n_rbytes);
    host(0, 3'd4, 1, 0, r, l);
    chk("R6 read 16", r, 32'h0000A1A0);
    s0 = n_strb;
    host(1, 3'd4, 0, 32'h77, r, l);
    chk("R1 write blocked in read mode", n_strb - s0, 0);
  endtask

  task automatic t_timeout();
    logic [31:0] r; int l, s0;
    resp_en = 0; s0 = n_strb;
    host(0, 3'd4, 1, 0, r, l);
    chk("R3 timeout read bytes", r, 32'hFFFF);
    chk("R3 remaining bytes abandoned", n_strb - s0, 1);
    chk("R9 stalled until timeout", (l >= 16) ? 1 : 0, 1);
    resp_en = 1;
    host(0, 3'd1, 0, 0, r, l);
    chk("R3 R5 flag set", r, 32'hA7);
    host(0, 3'd1, 0, 0, r, l);
    chk("R3 flag sticky", r[0], 1'b1);
    host(1, 3'd1, 0, 32'hFE, r, l);
    host(0, 3'd1, 0, 0, r, l);
    chk("R4 clear with bit0=0 ignored", r[0], 1'b1);
    host(1, 3'd1, 0, 32'h01, r, l);
    host(0, 3'd1, 0, 0, r, l);
    chk("R4 clear with bit0=1", r[0], 1'b0);
  endtask

  task automatic t_data_reg();
    logic [31:0] r; int l, u0;
    u0 = n_dupd;
    host(1, 3'd0, 0, 32'h33, r, l);
    repeat (2) @(negedge clk);
    chk("R8 latch loaded", pd_o, 8'h33);
    host(1, 3'd0, 0, 32'h33, r, l);
    repeat (2) @(negedge clk);
    chk("R8 equal data suppressed", n_dupd - u0, 1);
    host(1, 3'd0, 0, 32'h34, r, l);
    repeat (2) @(negedge clk);
    chk("R8 changed data pulses", n_dupd - u0, 2);
  endtask

  initial begin
    status = 8'hA6;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_gate_write();
    t_ctrl();
    t_addr_write();
    t_data_write(2, 32'h44332211, 4);
    resp_dly = 3;
    t_data_write(1, 32'h0000BEEF, 2);
    resp_dly = 0;
    t_data_write(0, 32'h000000C3, 1);
    t_gate_read();
    t_read_mode();
    t_timeout();
    t_data_reg();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule